// File: doc/BRIEF.md
# Write-Only Control Register Target on a Two-Wire Bus

This block is a target on a two-wire serial control bus (I2C). A controller programs the video and keying settings of the chip through it. Every transfer has the same shape: a START condition, the target address with the write bit, a subaddress, one data byte and a STOP condition. The target pulls SDA low in the acknowledge slot of each byte that it accepts.

Three 8-bit control words are held inside the block. Their fields drive the video format and keying logic directly as parallel outputs. SCL and SDA are oversampled in the pixel clock domain, so programming only works while that clock runs. The active-low reset clears every control bit.

Reads, clock stretching and multi-controller arbitration are not supported.

Top module: `vk_ctrl_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1011111 and whose last bit (R/W) is 0 is acknowledged. To acknowledge, the target holds `sda_pull_o` high from the SCL fall after the eighth bit to the SCL fall that ends the ninth clock.
- R2: Once the address is accepted, the following subaddress byte and data byte are both acknowledged.
- R3: Subaddress 0 stores the data byte as follows. `key_mode_o` = bits 7:5, `uv_offset_o` = bit 4, `key_en_o` = bit 3, `key_inv_o` = bit 2, `fmt_o` = bits 1:0.
- R4: Subaddress 1 stores bits 2:0 of the data byte on `key_dly_o`. Bits 7:3 are discarded.
- R5: Subaddress 2 stores all 8 data bits on `key_ref_o`.
- R6: While `rst_n` is low, every control output is 0 and `sda_pull_o` is 0.
- R7: The target does not acknowledge in these two cases: an address that does not match, or an address with R/W = 1. The target then acknowledges no further byte and changes no output until the next START.
- R8: A write to a subaddress of 3 or more is acknowledged but changes no output.
- R9: A repeated START restarts address decoding. A transfer that a repeated START cuts off before its data byte writes nothing.
- R10: A second data byte in the same transfer is not acknowledged and is not stored.
- R11: `sda_pull_o` changes only right after a falling edge of the synchronised SCL. It is never high outside an acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain oversampling clock |
| rst_n | input | 1 | Active-low reset, clears all control bits |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | Drives SDA low through an open-drain pad when 1 |
| key_mode_o | output | 3 | Keying mode field |
| uv_offset_o | output | 1 | Chroma code: 0 two's complement, 1 offset binary |
| key_en_o | output | 1 | Keying enable |
| key_inv_o | output | 1 | External key polarity select |
| fmt_o | output | 2 | Video input format field |
| key_dly_o | output | 3 | Added keying delay in pixel clocks |
| key_ref_o | output | 8 | Colour-key compare value |

## Verification
The assertions assume the controller changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL high and low phase lasts several system clocks longer than the two-flop synchroniser delay. Without this, the edge detector could pair a data edge with the wrong clock phase. The bench meets both conditions by construction. Each bus phase lasts four or eight system clocks, and the task that sends a bit drives SDA only after SCL has gone low. The bench models the wired-AND bus as the controller's drive ANDed with the inverse of `sda_pull_o`. The acknowledge value is therefore read off the same wire the target sees.

// File: rtl/vk_pkg.sv
package vk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } xfer_st_e;

  typedef struct packed {
    logic [2:0] key_mode;
    logic       uv_offset;
    logic       key_en;
    logic       key_inv;
    logic [1:0] fmt;
    logic [2:0] key_dly;
    logic [7:0] key_ref;
  } ctrl_fields_t;

  // Address byte check: upper seven bits match, write direction only.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] tgt);
    return (b[7:1] == tgt) && (b[0] == 1'b0);
  endfunction

  // Bits kept by each control word; word 1 keeps only its delay field.
  function automatic logic [7:0] keep_mask(input int idx);
    return (idx == 1) ? 8'h07 : 8'hFF;
  endfunction

  function automatic ctrl_fields_t split_fields(input logic [7:0] w0,
                                                input logic [7:0] w1,
                                                input logic [7:0] w2);
    ctrl_fields_t f;
    f.key_mode  = w0[7:5];
    f.uv_offset = w0[4];
    f.key_en    = w0[3];
    f.key_inv   = w0[2];
    f.fmt       = w0[1:0];
    f.key_dly   = w1[2:0];
    f.key_ref   = w2;
    return f;
  endfunction

endpackage

// File: rtl/vk_pin_sync.sv
module vk_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe_q[0] <= 1'b1;
          else        pipe_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe_q[s] <= 1'b1;
          else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vk_xfer_fsm.sv
module vk_xfer_fsm
  import vk_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1011111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       sda_pull_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_sub_o,
  output logic [7:0] wr_data_o
);
  localparam int BITS = 8;

  logic       scl_d_q, sda_d_q;
  xfer_st_e   st_q;
  logic [3:0] cnt_q;
  logic [1:0] idx_q;
  logic [7:0] sh_q, sub_q;
  logic       pull_q;

  // Named bus events for the assertions.
  logic scl_rise_w, scl_fall_w, start_w, stop_w, byte_end_w, addr_nack_w;

  assign scl_rise_w  = !scl_d_q && scl_s;
  assign scl_fall_w  = scl_d_q && !scl_s;
  assign start_w     = scl_d_q && scl_s && sda_d_q && !sda_s;
  assign stop_w      = scl_d_q && scl_s && !sda_d_q && sda_s;
  assign byte_end_w  = (st_q == ST_RX) && (cnt_q == 4'(BITS)) && scl_fall_w;
  assign addr_nack_w = byte_end_w && (idx_q == 2'd0) && !addr_hit(sh_q, TGT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s;
      sda_d_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      sub_q  <= '0;
      pull_q <= 1'b0;
    end else if (start_w) begin
      st_q   <= ST_RX;
      cnt_q  <= '0;
      idx_q  <= '0;
      pull_q <= 1'b0;
    end else if (stop_w) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise_w && cnt_q < 4'(BITS)) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end_w) begin
            if (addr_nack_w) begin
              st_q <= ST_SKIP;
            end else begin
              if (idx_q == 2'd1) sub_q <= sh_q;
              st_q   <= ST_ACK;
              pull_q <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_w) begin
            pull_q <= 1'b0;
            cnt_q  <= '0;
            if (idx_q == 2'd2) begin
              st_q <= ST_SKIP;
            end else begin
              idx_q <= idx_q + 2'd1;
              st_q  <= ST_RX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_stb_o   = byte_end_w && (idx_q == 2'd2) && !start_w && !stop_w;
  assign wr_sub_o   = sub_q;
  assign wr_data_o  = sh_q;

  // R11
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall_w));
  // R11
  pull_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (st_q == ST_ACK));
  // R7
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_nack_w && !start_w && !stop_w) |=> (!pull_q && st_q == ST_SKIP));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (st_q == ST_RX && cnt_q == 4'd0 && idx_q == 2'd0 && !pull_q));
endmodule

// File: rtl/vk_ctrl_regs.sv
module vk_ctrl_regs
  import vk_pkg::*;
#(
  parameter int NUM_REGS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb_i,
  input  logic [7:0]   wr_sub_i,
  input  logic [7:0]   wr_data_i,
  output ctrl_fields_t fields_o
);
  logic [7:0] regs_q [NUM_REGS];

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) regs_q[r] <= '0;
        else if (wr_stb_i && wr_sub_i == 8'(r))
          regs_q[r] <= wr_data_i & keep_mask(r);
    end
  endgenerate

  assign fields_o = split_fields(regs_q[0], regs_q[1], regs_q[2]);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb_i || wr_sub_i >= 8'(NUM_REGS)) |=> $stable(fields_o));
  // R4
  dly_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && wr_sub_i == 8'd1) |=> (fields_o.key_dly == $past(wr_data_i[2:0])));
endmodule

// File: rtl/vk_ctrl_target.sv
module vk_ctrl_target
  import vk_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'b1011111,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [2:0] key_mode_o,
  output logic       uv_offset_o,
  output logic       key_en_o,
  output logic       key_inv_o,
  output logic [1:0] fmt_o,
  output logic [2:0] key_dly_o,
  output logic [7:0] key_ref_o
);
  logic         scl_s, sda_s, wr_stb;
  logic [7:0]   wr_sub, wr_data;
  ctrl_fields_t fields;

  vk_pin_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
  vk_pin_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

  vk_xfer_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb),
    .wr_sub_o(wr_sub), .wr_data_o(wr_data));

  vk_ctrl_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb),
    .wr_sub_i(wr_sub), .wr_data_i(wr_data), .fields_o(fields));

  assign key_mode_o  = fields.key_mode;
  assign uv_offset_o = fields.uv_offset;
  assign key_en_o    = fields.key_en;
  assign key_inv_o   = fields.key_inv;
  assign fmt_o       = fields.fmt;
  assign key_dly_o   = fields.key_dly;
  assign key_ref_o   = fields.key_ref;
endmodule

// File: tb/vk_ctrl_target_tb_top.sv
module vk_ctrl_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_bus;
  logic [2:0] key_mode, key_dly;
  logic uv_offset, key_en, key_inv;
  logic [1:0] fmt;
  logic [7:0] key_ref;

  int tests = 0, fails = 0;
  bit done = 0, cmp_en = 0, mism_seen = 0;
  int exp_w [3];

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  vk_ctrl_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .key_mode_o(key_mode), .uv_offset_o(uv_offset),
    .key_en_o(key_en), .key_inv_o(key_inv), .fmt_o(fmt),
    .key_dly_o(key_dly), .key_ref_o(key_ref));

  // Model view of the outputs, rebuilt from expected word values.
  function automatic logic [19:0] model_out();
    int m, c, e, p, f;
    m = exp_w[0] / 32; c = (exp_w[0] / 16) % 2; e = (exp_w[0] / 8) % 2;
    p = (exp_w[0] / 4) % 2; f = exp_w[0] % 4;
    return {3'(m), 1'(c), 1'(e), 1'(p), 2'(f), 3'(exp_w[1] % 8), 8'(exp_w[2])};
  endfunction

  function automatic logic [19:0] dut_out();
    return {key_mode, uv_offset, key_en, key_inv, fmt, key_dly, key_ref};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model while the bus is quiet (R3 R4 R5).
  always @(negedge clk) begin
    if (cmp_en && rst_n && dut_out() !== model_out() && !mism_seen) begin
      mism_seen = 1;
      fails++;
      $display("FAIL R3/R4/R5 per-clock actual=0x%0h expected=0x%0h", dut_out(), model_out());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; tick(4); m_scl = 1; tick(8); m_sda = 0; tick(8); m_scl = 0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 0; tick(4); m_scl = 1; tick(8); m_sda = 1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(4); m_scl = 1; tick(8); m_scl = 0; tick(4);
    end
    m_sda = 1; tick(4); m_scl = 1; tick(4);
    ack = !sda_bus;
    tick(4); m_scl = 0; tick(4);
  endtask

  // Full write frame with expected acks and model update.
  task automatic write_frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                             input string req);
    bit ack; bit hit;
    hit = (a == 8'hBE);
    cmp_en = 0;
    bus_start();
    send_byte(a, ack);
    check(ack == hit, {req, " addr ack (R1/R7)"}, ack, hit);
    send_byte(s, ack);
    check(ack == hit, {req, " sub ack (R2/R7)"}, ack, hit);
    send_byte(d, ack);
    check(ack == hit, {req, " data ack (R2/R8)"}, ack, hit);
    if (hit && s == 0) exp_w[0] = d;
    if (hit && s == 1) exp_w[1] = d % 8;
    if (hit && s == 2) exp_w[2] = d;
    bus_stop();
    tick(4);
    cmp_en = 1;
  endtask

  initial begin
    bit ack;
    foreach (exp_w[k]) exp_w[k] = 0;
    tick(5);
    // R6 reset state
    check(dut_out() == 20'h0 && !sda_pull, "R6 outputs in reset", dut_out(), 0);
    rst_n = 1; tick(5);
    cmp_en = 1;
    check(dut_out() == 20'h0, "R6 after release", dut_out(), 0);

    // R3 word 0 fields
    write_frame(8'hBE, 8'h00, 8'hB6, "R3");
    check(key_mode == 3'b101, "R3 key_mode", key_mode, 5);
    check({uv_offset, key_en, key_inv} == 3'b101, "R3 flags", {uv_offset, key_en, key_inv}, 5);
    check(fmt == 2'b10, "R3 fmt", fmt, 2);
    write_frame(8'hBE, 8'h00, 8'h49, "R3");
    check({key_mode, uv_offset, key_en, key_inv, fmt} == 8'h49, "R3 second pattern",
          {key_mode, uv_offset, key_en, key_inv, fmt}, 8'h49);

    // R4 word 1, upper bits discarded
    write_frame(8'hBE, 8'h01, 8'hFD, "R4");
    check(key_dly == 3'd5, "R4 key_dly", key_dly, 5);

    // R5 word 2
    write_frame(8'hBE, 8'h02, 8'hA5, "R5");
    check(key_ref == 8'hA5, "R5 key_ref", key_ref, 8'hA5);

    // R7 read direction and wrong address
    write_frame(8'hBF, 8'h02, 8'h00, "R7 read");
    write_frame(8'hBC, 8'h00, 8'hFF, "R7 mismatch");
    check(key_ref == 8'hA5 && key_mode == 3'b010, "R7 no change", key_ref, 8'hA5);

    // R8 out-of-range subaddress
    write_frame(8'hBE, 8'h03, 8'h77, "R8");
    write_frame(8'hBE, 8'hFF, 8'h12, "R8");
    check(dut_out() == model_out(), "R8 no change", dut_out(), model_out());

    // R9 repeated START cuts a transfer before its data byte
    cmp_en = 0;
    bus_start();
    send_byte(8'hBE, ack); check(ack, "R9 first addr ack", ack, 1);
    send_byte(8'h02, ack); check(ack, "R9 first sub ack", ack, 1);
    bus_start();
    send_byte(8'hBE, ack); check(ack, "R9 restart addr ack", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h3C, ack); check(ack, "R9 restart data ack", ack, 1);
    exp_w[0] = 8'h3C;
    bus_stop(); tick(4); cmp_en = 1;
    check(key_ref == 8'hA5, "R9 cut transfer wrote nothing", key_ref, 8'hA5);
    check({key_mode, uv_offset, key_en, key_inv, fmt} == 8'h3C, "R9 restarted write",
          {key_mode, uv_offset, key_en, key_inv, fmt}, 8'h3C);

    // R10 extra data byte
    cmp_en = 0;
    bus_start();
    send_byte(8'hBE, ack);
    send_byte(8'h02, ack);
    send_byte(8'h11, ack); check(ack, "R10 first data ack", ack, 1);
    exp_w[2] = 8'h11;
    send_byte(8'h22, ack); check(!ack, "R10 extra byte nack", ack, 0);
    bus_stop(); tick(4); cmp_en = 1;
    check(key_ref == 8'h11, "R10 extra not stored", key_ref, 8'h11);

    // R11 pull released once idle
    check(!sda_pull, "R11 pull idle", sda_pull, 0);

    // R6 reset clears programmed state
    cmp_en = 0;
    rst_n = 0; tick(3);
    check(dut_out() == 20'h0 && !sda_pull, "R6 reset clears", dut_out(), 0);
    foreach (exp_w[k]) exp_w[k] = 0;
    rst_n = 1; tick(3); cmp_en = 1; tick(20);

    tests++;  // per-clock model comparison over the whole run
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule